// File: doc/BRIEF.md
# Lockstep Start/Stop Controller for Parallel Sequencer Cores

This block starts and stops a group of parallel sequencer cores together. A start comes from either a software start pulse or a falling edge on an active-low trigger pin. A stop comes from either a software stop pulse or an active-low reset pin. The block turns these requests into per-core start and reset strobes. All the strobes come from one clock, so every selected core leaves idle on the same edge.

The two pins are asynchronous. They idle high, and the block synchronises them internally. The start path has a fixed latency of seven clock edges, counted from the first edge that samples the trigger low. The stop path has a latency of one edge. An enable mask picks which cores receive a start. Each core reports a busy level. A trigger is dropped in three cases: while any enabled core is busy, while an earlier start is still in flight, or when a stop request arrives close enough to overrule it.

Top module: `trig_rst_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with both pins high and no software request, `coreStart` and `coreReset` are all zero.
- R2: The trigger and reset pins are active low and idle high. A pin driven low for one clock period, so that a single rising clock edge samples it low, is recognised.
- R3: If the first rising edge that samples `hwTrigN` low is edge k, and the trigger is accepted, `coreStart` is nonzero during exactly one cycle, the one that follows edge k+7.
- R4: If `hwResetN` is sampled low at edge m, every bit of `coreReset` is 1 during the cycle after edge m+1. This holds once for each edge at which the pin is sampled low.
- R5: Bit i of `coreStart` is bit i of `coreEnable` as sampled at the issuing edge. All enabled bits rise on the same edge, and disabled cores get no start.
- R6: `swStart` sampled high at an edge acts as `hwTrigN` sampled low at that edge. `swStop` sampled high acts as `hwResetN` sampled low. The two sources are ORed together.
- R7: A start request held active over many edges produces one start. A new start needs the request to be sampled inactive at one edge or more first.
- R8: A trigger first sampled at edge k is discarded, not queued, if `coreBusy & coreEnable` is nonzero at edge k+2. A busy bit on a disabled core does not block.
- R9: A trigger is discarded if a start from an earlier accepted trigger has not yet been issued.
- R10: A stop request sampled at any edge from k to k+6 cancels the start for a trigger first sampled at edge k. This includes a stop at the same edge as the trigger. `coreStart` and `coreReset` are never nonzero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the controller and all cores |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| hwTrigN | input | 1 | Asynchronous active-low trigger pin, idles high |
| hwResetN | input | 1 | Asynchronous active-low stop pin, idles high |
| swStart | input | 1 | Synchronous software start request, active high |
| swStop | input | 1 | Synchronous software stop request, active high |
| coreEnable | input | NUM_CORES | Bit i selects core i for starts |
| coreBusy | input | NUM_CORES | Bit i is high while core i is running |
| coreStart | output | NUM_CORES | One-cycle start strobe per core, aligned across cores |
| coreReset | output | NUM_CORES | Stop strobe to every core |

## Verification
The bench targets the edges of the timing windows. These include a trigger and a stop sampled on the same edge, a stop arriving just before an in-flight start would issue, and a second trigger only a few cycles behind the first. A design with an off-by-one in the flush window would issue a start that should have been cancelled, or put a start and a reset in the same cycle. A design without edge detection would restart cores again and again while the pin is held low. A design that masked busy with the wrong bits would either start cores on top of a running program or refuse to start when only a disabled core is busy. A long pseudo-random phase compares every output on every cycle against a behavioural model, so any latency change or wrong mask bit shows up at once.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // Strobes from the control decision logic into the datapath
  typedef struct packed {
    logic launch;  // accept the detected trigger into the start delay line
    logic flush;   // drop every in-flight start and issue a core reset
  } trc_ctl_t;
endpackage

// File: rtl/trc_control.sv
module trc_control
  import trc_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trigRise,
  input  logic                 rstNow,
  input  logic                 rstBlock,
  input  logic                 pending,
  input  logic [NUM_CORES-1:0] coreBusy,
  input  logic [NUM_CORES-1:0] coreEnable,
  output trc_ctl_t             ctl
);
  logic anyBusy;

  always_comb begin
    anyBusy    = |(coreBusy & coreEnable);
    ctl.launch = trigRise & ~rstBlock & ~pending & ~anyBusy;
    ctl.flush  = rstNow;
  end

  // R7: a rising request edge can never be detected on two consecutive cycles
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.launch |=> !ctl.launch);
endmodule

// File: rtl/trc_datapath.sv
module trc_datapath
  import trc_pkg::*;
#(
  parameter int NUM_CORES    = 2,
  parameter int TRIG_LATENCY = 7,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hwTrigN,
  input  logic                 hwResetN,
  input  logic                 swStart,
  input  logic                 swStop,
  input  logic [NUM_CORES-1:0] coreEnable,
  input  trc_ctl_t             ctl,
  output logic                 trigRise,
  output logic                 rstNow,
  output logic                 rstBlock,
  output logic                 pending,
  output logic [NUM_CORES-1:0] coreStart,
  output logic [NUM_CORES-1:0] coreReset
);
  localparam int DLY  = TRIG_LATENCY - SYNC_STAGES;
  localparam int HIST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] trigSync;
  logic                   trigPrev;
  logic                   rstReqQ;
  logic [HIST-1:0]        rstHist;
  logic [DLY-1:0]         dly;
  logic                   fire;

  // Request synchronisers: trigger takes SYNC_STAGES flops, stop takes one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trigSync <= '0;
      trigPrev <= 1'b0;
      rstReqQ  <= 1'b0;
    end else begin
      trigSync <= {trigSync[SYNC_STAGES-2:0], (~hwTrigN | swStart)};
      trigPrev <= trigSync[SYNC_STAGES-1];
      rstReqQ  <= ~hwResetN | swStop;
    end
  end

  // Stop history spanning the trigger synchroniser depth
  generate
    if (HIST == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rstHist <= '0;
        else        rstHist <= rstReqQ;
      end
    end else begin : g_histN
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rstHist <= '0;
        else        rstHist <= {rstHist[HIST-2:0], rstReqQ};
      end
    end
  endgenerate

  // Start delay line
  generate
    if (DLY == 1) begin : g_dly1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dly <= '0;
        else if (ctl.flush) dly <= '0;
        else                dly <= ctl.launch;
      end
    end else begin : g_dlyN
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dly <= '0;
        else if (ctl.flush) dly <= '0;
        else                dly <= {dly[DLY-2:0], ctl.launch};
      end
    end
  endgenerate

  always_comb begin
    trigRise = trigSync[SYNC_STAGES-1] & ~trigPrev;
    rstNow   = rstReqQ;
    rstBlock = rstReqQ | (|rstHist);
    pending  = |dly;
    fire     = dly[DLY-1];
  end

  // Output strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coreStart <= '0;
      coreReset <= '0;
    end else begin
      coreStart <= (fire && !ctl.flush) ? coreEnable : '0;
      coreReset <= ctl.flush ? '1 : '0;
    end
  end

  // R10: start and reset strobes never coincide
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((|coreStart) && (|coreReset)));
  // R4: a synchronised stop request gives a full reset on the next cycle
  a_r4_reset_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rstReqQ |=> (&coreReset));
  // R3: a start only leaves the end of the delay line
  a_r3_start_from_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    (|coreStart) |-> $past(fire));
  // R3: a start strobe lasts a single cycle
  a_r3_start_once: assert property (@(posedge clk) disable iff (!rst_n)
    (|coreStart) |=> (coreStart == '0));
endmodule

// File: rtl/trig_rst_ctrl.sv
module trig_rst_ctrl
  import trc_pkg::*;
#(
  parameter int NUM_CORES    = 2,
  parameter int TRIG_LATENCY = 7,  // must be at least SYNC_STAGES + 1
  parameter int SYNC_STAGES  = 2   // must be at least 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hwTrigN,
  input  logic                 hwResetN,
  input  logic                 swStart,
  input  logic                 swStop,
  input  logic [NUM_CORES-1:0] coreEnable,
  input  logic [NUM_CORES-1:0] coreBusy,
  output logic [NUM_CORES-1:0] coreStart,
  output logic [NUM_CORES-1:0] coreReset
);
  trc_ctl_t ctl;
  logic     trigRise;
  logic     rstNow;
  logic     rstBlock;
  logic     pending;

  trc_datapath #(
    .NUM_CORES   (NUM_CORES),
    .TRIG_LATENCY(TRIG_LATENCY),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hwTrigN   (hwTrigN),
    .hwResetN  (hwResetN),
    .swStart   (swStart),
    .swStop    (swStop),
    .coreEnable(coreEnable),
    .ctl       (ctl),
    .trigRise  (trigRise),
    .rstNow    (rstNow),
    .rstBlock  (rstBlock),
    .pending   (pending),
    .coreStart (coreStart),
    .coreReset (coreReset)
  );

  trc_control #(
    .NUM_CORES(NUM_CORES)
  ) ctl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigRise  (trigRise),
    .rstNow    (rstNow),
    .rstBlock  (rstBlock),
    .pending   (pending),
    .coreBusy  (coreBusy),
    .coreEnable(coreEnable),
    .ctl       (ctl)
  );

  // R9: a pending start always blocks a new launch
  a_r9_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.launch |=> pending);
endmodule

// File: tb/trig_rst_ctrl_tb_top.sv
module trig_rst_ctrl_tb_top;
  localparam int NC   = 2;
  localparam int LAT  = 7;
  localparam int SYN  = 2;
  localparam int MAXC = 8192;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          hwTrigN = 1'b1, hwResetN = 1'b1, swStart = 1'b0, swStop = 1'b0;
  logic [NC-1:0] coreEnable = '1, coreBusy = '0;
  logic [NC-1:0] coreStart, coreReset;

  trig_rst_ctrl #(.NUM_CORES(NC), .TRIG_LATENCY(LAT), .SYNC_STAGES(SYN)) dut_i (
    .clk(clk), .rst_n(rst_n), .hwTrigN(hwTrigN), .hwResetN(hwResetN),
    .swStart(swStart), .swStop(swStop), .coreEnable(coreEnable),
    .coreBusy(coreBusy), .coreStart(coreStart), .coreReset(coreReset));

  int checks = 0, fails = 0, cyc = 0, startCount = 0, rstCycles = 0;
  bit done = 1'b0;
  logic [NC-1:0] lastStart = '0;
  bit tq[MAXC], rq[MAXC], bz[MAXC], la[MAXC];
  logic [NC-1:0] en[MAXC];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit tqAt(int i); return (i >= 1 && i < MAXC) ? tq[i] : 1'b0; endfunction
  function automatic bit rqAt(int i); return (i >= 1 && i < MAXC) ? rq[i] : 1'b0; endfunction
  function automatic bit laAt(int i); return (i >= 1 && i < MAXC) ? la[i] : 1'b0; endfunction

  // Behavioural model: record sampled requests, decide acceptance per trigger edge
  always @(posedge clk) begin
    if (rst_n && cyc < MAXC - 1) begin
      int j;
      bit ok;
      cyc = cyc + 1;
      tq[cyc] = !hwTrigN || swStart;
      rq[cyc] = !hwResetN || swStop;
      bz[cyc] = |(coreBusy & coreEnable);
      en[cyc] = coreEnable;
      j = cyc - SYN;
      ok = tqAt(j) && !tqAt(j - 1) && !bz[cyc];
      for (int m = j; m < j + SYN; m++) if (rqAt(m)) ok = 1'b0;
      for (int jp = j - (LAT - SYN); jp < j; jp++) begin
        if (laAt(jp)) begin
          bit alive = 1'b1;
          for (int m = jp; m <= j; m++) if (rqAt(m)) alive = 1'b0;
          if (alive) ok = 1'b0;
        end
      end
      if (j >= 1) la[j] = ok;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cyc >= 1 && !done) begin
      logic [NC-1:0] expS, expR;
      int j;
      bit live;
      j = cyc - LAT;
      live = laAt(j);
      for (int m = j; m < cyc; m++) if (rqAt(m)) live = 1'b0;
      expS = live ? en[cyc] : '0;
      expR = rqAt(cyc - 1) ? '1 : '0;
      chk("R3 start vs model", 32'(coreStart), 32'(expS));
      chk("R4 reset vs model", 32'(coreReset), 32'(expR));
      chk("R10 no overlap", 32'((|coreStart) && (|coreReset)), 32'd0);
      if (coreStart != '0) begin startCount++; lastStart = coreStart; end
      if (coreReset != '0) rstCycles++;
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic trigPulse(int len);
    hwTrigN = 1'b0; idle(len); hwTrigN = 1'b1;
  endtask

  initial begin
    int s0, r0;
    logic [15:0] lfsr = 16'hACE1;
    idle(3);
    chk("R1 start in reset", 32'(coreStart), 32'd0);
    chk("R1 reset in reset", 32'(coreReset), 32'd0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 start idle", 32'(coreStart), 32'd0);
    chk("R1 reset idle", 32'(coreReset), 32'd0);

    // R2/R3: one-period trigger, start exactly after edge k+7
    s0 = startCount;
    hwTrigN = 1'b0; idle(1); hwTrigN = 1'b1;
    idle(6);
    chk("R3 no start before k+7", 32'(startCount - s0), 32'd0);
    idle(1);
    chk("R3 start at k+7", 32'(coreStart), 32'h3);
    idle(6);
    chk("R2 one-period trigger recognised", 32'(startCount - s0), 32'd1);
    chk("R5 all enabled cores together", 32'(lastStart), 32'h3);

    // R7: held low gives a single start
    s0 = startCount;
    trigPulse(30); idle(12);
    chk("R7 held trigger one start", 32'(startCount - s0), 32'd1);

    // R5: mask selects cores
    coreEnable = 2'b01; s0 = startCount;
    trigPulse(1); idle(12);
    chk("R5 masked start count", 32'(startCount - s0), 32'd1);
    chk("R5 masked start bits", 32'(lastStart), 32'h1);

    // R8: enabled busy core blocks; busy disabled core does not
    coreEnable = 2'b11; coreBusy = 2'b10; s0 = startCount;
    trigPulse(1); idle(12);
    chk("R8 busy blocks trigger", 32'(startCount - s0), 32'd0);
    coreEnable = 2'b10; coreBusy = 2'b01; s0 = startCount;
    trigPulse(1); idle(12);
    chk("R8 busy on disabled core ignored", 32'(startCount - s0), 32'd1);
    chk("R8 start bits", 32'(lastStart), 32'h2);
    coreEnable = 2'b11; coreBusy = 2'b00;

    // R9: second trigger while first is pending
    s0 = startCount;
    trigPulse(1); idle(2); trigPulse(1); idle(14);
    chk("R9 pending trigger ignored", 32'(startCount - s0), 32'd1);

    // R6: software start and stop
    s0 = startCount; r0 = rstCycles;
    swStart = 1'b1; idle(1); swStart = 1'b0; idle(12);
    chk("R6 software start", 32'(startCount - s0), 32'd1);
    swStop = 1'b1; idle(1); swStop = 1'b0; idle(4);
    chk("R6 software stop", 32'(rstCycles - r0), 32'd1);

    // R4: reset pin held three edges
    r0 = rstCycles;
    hwResetN = 1'b0; idle(3); hwResetN = 1'b1; idle(4);
    chk("R4 reset cycles", 32'(rstCycles - r0), 32'd3);

    // R10: same-edge trigger and reset, reset mid-flight, reset after start
    s0 = startCount;
    hwTrigN = 1'b0; hwResetN = 1'b0; idle(1); hwTrigN = 1'b1; hwResetN = 1'b1;
    idle(12);
    chk("R10 same-edge reset wins", 32'(startCount - s0), 32'd0);
    s0 = startCount;
    trigPulse(1); idle(5); hwResetN = 1'b0; idle(1); hwResetN = 1'b1; idle(12);
    chk("R10 late reset cancels", 32'(startCount - s0), 32'd0);
    s0 = startCount;
    trigPulse(1); idle(9); hwResetN = 1'b0; idle(1); hwResetN = 1'b1; idle(6);
    chk("R10 reset after start keeps start", 32'(startCount - s0), 32'd1);

    // Pseudo-random phase checked against the model every cycle
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hwTrigN  = (lfsr[3:0] != 4'h0);
      hwResetN = (lfsr[9:4] != 6'h0);
      swStart  = (lfsr[14:9] == 6'h15);
      swStop   = (lfsr[15:8] == 8'hA5);
      if (lfsr[7:5] == 3'h0) coreBusy = lfsr[12:11];
      if (lfsr[15:12] == 4'h9) coreEnable = lfsr[2:1];
      idle(1);
    end
    hwTrigN = 1'b1; hwResetN = 1'b1; swStart = 1'b0; swStop = 1'b0;
    idle(12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R3 watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule